// File: doc/BRIEF.md
# Warp Memory Instruction Tracker

This block sits between the instruction issue stage and a cache that has one request port per lane. It takes one memory instruction at a time. An instruction carries an active-lane mask, one address per lane, a write flag and an ordering-barrier flag. For every active lane it sends one request on that lane's own port. All lanes of the instruction carry the same tag, and that tag is the index of the slot the instruction holds in a small table of in-flight instructions.

Each table slot keeps the instruction's identifier, its write flag, the cycle in which it was accepted, and a bit per lane that is still waiting for its response. A response on lane port p with tag t clears bit p of slot t. A slot whose lane bits are all clear is complete. Complete slots are retired one per cycle through a single result port, with the lowest slot first, and each result reports how many cycles the instruction spent in flight. A barrier instruction issues no requests. It blocks the input until every slot is free, then produces its own result.

Top module: `lsu_tag_tracker`

## Requirements
- R1: During and after reset, `in_ready` is 1, `out_valid` is 0 and every bit of `req_valid` is 0.
- R2: In the cycle after a non-barrier instruction is accepted, `req_valid` equals its lane mask. Each active lane L shows that lane's address on `req_addr[L*32 +: 32]`, and `req_write[L]` equals the instruction's write flag.
- R3: All active lanes of an instruction carry the same tag on `req_tag[L*2 +: 2]`. That tag is the lowest-numbered table slot that is free when the instruction is accepted, so a slot is reused once it retires.
- R4: If the last outstanding lane response of an instruction is presented in cycle c, `out_valid` is 1 in cycle c+2. The result carries the instruction's identifier and write flag, with `out_fence` 0.
- R5: Responses may come back in any lane order, spread over any number of cycles, and from different instructions interleaved. An instruction with some lanes still outstanding produces no result.
- R6: While all DEPTH slots are occupied, `in_ready` is 0. Input is accepted again in the cycle after a slot retires.
- R7: A barrier instruction is accepted, issues no requests and holds `in_ready` at 0. Its result, with `out_fence` 1, appears in the cycle after the first cycle in which it is held with every slot free.
- R8: `out_latency` equals the cycle in which the result is visible, minus the cycle of acceptance, minus one.
- R9: When several slots are complete at once, their results appear on consecutive cycles, lowest slot first. `in_ready` stays 0 while any complete slot is waiting.
- R10: An instruction with an all-zero lane mask issues no requests. Its result appears in the second cycle after acceptance, with latency 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present at the input |
| in_ready | output | 1 | Instruction accepted on this edge when valid |
| in_mask | input | LANES | Active-lane mask |
| in_addr | input | LANES*32 | Per-lane addresses, lane L in bits L*32 and up |
| in_store | input | 1 | Write flag |
| in_fence | input | 1 | Ordering-barrier flag |
| in_id | input | 8 | Instruction identifier |
| req_valid | output | LANES | Per-lane request strobe |
| req_addr | output | LANES*32 | Per-lane request address |
| req_write | output | LANES | Per-lane write bit |
| req_tag | output | LANES*TAG_W | Per-lane tag (slot index) |
| rsp_valid | input | LANES | Per-lane response strobe |
| rsp_tag | input | LANES*TAG_W | Per-lane response tag |
| out_valid | output | 1 | Result strobe, one cycle per instruction |
| out_id | output | 8 | Identifier of the retired instruction |
| out_store | output | 1 | Write flag of the retired instruction |
| out_fence | output | 1 | Result belongs to a barrier |
| out_latency | output | 16 | Cycles in flight |

## Verification
The assertions check several things on every cycle. A slot is never allocated when the table is full. Only complete slots are released. A response for a live slot always clears its lane bit. Requests never appear on lanes outside the accepted mask. Every result traces back to a complete slot, or, for a barrier, to an empty table. Other behaviour can only be shown by the bench's scenarios: which slot gets reused, the exact cycle of each result, the lowest-slot-first order of simultaneous completions, the latency values, and the stall that a held barrier or a waiting completion imposes on the input.

// File: rtl/lsu_pkg.sv
package lsu_pkg;

    localparam int ADDR_W = 32;
    localparam int ID_W   = 8;
    localparam int LAT_W  = 16;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [ID_W-1:0]   id_t;
    typedef logic [LAT_W-1:0]  cyc_t;

    // Per-slot bookkeeping captured on acceptance
    typedef struct packed {
        id_t  id;
        logic store;
        cyc_t issue;
    } slot_meta_t;

    // Result word driven on the output port
    typedef struct packed {
        id_t  id;
        logic store;
        logic fence;
        cyc_t latency;
    } result_t;

    function automatic cyc_t elapsed(cyc_t now, cyc_t start);
        return now - start;
    endfunction

endpackage

// File: rtl/lsu_lane_issue.sv
module lsu_lane_issue
    import lsu_pkg::*;
#(
    parameter int LANES = 4,
    parameter int TAG_W = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fire,
    input  logic [LANES-1:0]        mask,
    input  logic [LANES*ADDR_W-1:0] addr,
    input  logic                    write,
    input  logic [TAG_W-1:0]        tag,
    output logic [LANES-1:0]        req_valid,
    output logic [LANES*ADDR_W-1:0] req_addr,
    output logic [LANES-1:0]        req_write,
    output logic [LANES*TAG_W-1:0]  req_tag
);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_valid <= '0;
        end else begin
            req_valid <= fire ? mask : '0;
        end
    end

    // Payload registers load only for lanes that fire
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (fire && mask[l]) begin
                req_addr[l*ADDR_W +: ADDR_W] <= addr[l*ADDR_W +: ADDR_W];
                req_write[l]                 <= write;
                req_tag[l*TAG_W +: TAG_W]    <= tag;
            end
        end
    end

endmodule

// File: rtl/lsu_pend_table.sv
module lsu_pend_table
    import lsu_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 4,
    parameter int TAG_W = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   alloc_en,
    input  logic [LANES-1:0]       alloc_mask,
    input  slot_meta_t             alloc_meta,
    output logic [TAG_W-1:0]       alloc_idx,
    input  logic [LANES-1:0]       rsp_valid,
    input  logic [LANES*TAG_W-1:0] rsp_tag,
    input  logic                   release_en,
    input  logic [TAG_W-1:0]       release_idx,
    output slot_meta_t             release_meta,
    output logic [DEPTH-1:0]       done_vec,
    output logic                   full,
    output logic                   empty
);

    logic [DEPTH-1:0] valid_q;
    logic [LANES-1:0] pend_q [DEPTH];
    slot_meta_t       meta_q [DEPTH];
    logic [LANES-1:0] clr    [DEPTH];

    // Lowest free slot wins
    always_comb begin
        alloc_idx = '0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            if (!valid_q[e]) alloc_idx = TAG_W'(e);
        end
    end

    // Lane responses decoded into per-slot clear masks
    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            for (int l = 0; l < LANES; l++) begin
                clr[e][l] = rsp_valid[l] && valid_q[e]
                         && (rsp_tag[l*TAG_W +: TAG_W] == TAG_W'(e));
            end
        end
    end

    always_comb begin
        for (int e = 0; e < DEPTH; e++) begin
            done_vec[e] = valid_q[e] && (pend_q[e] == '0);
        end
    end

    assign full         = &valid_q;
    assign empty        = ~|valid_q;
    assign release_meta = meta_q[release_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            for (int e = 0; e < DEPTH; e++) pend_q[e] <= '0;
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (alloc_en && alloc_idx == TAG_W'(e)) begin
                    valid_q[e] <= 1'b1;
                    pend_q[e]  <= alloc_mask;
                end else begin
                    if (release_en && release_idx == TAG_W'(e)) valid_q[e] <= 1'b0;
                    pend_q[e] <= pend_q[e] & ~clr[e];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (alloc_en && alloc_idx == TAG_W'(e)) meta_q[e] <= alloc_meta;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        alloc_en |-> !full); // R6

    AST_RELEASE_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
        release_en |-> done_vec[release_idx]); // R4

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot_chk
        for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
            AST_RSP_CLEARS_LANE: assert property (@(posedge clk) disable iff (rst)
                (rsp_valid[l] && valid_q[e] && rsp_tag[l*TAG_W +: TAG_W] == TAG_W'(e))
                |=> !pend_q[e][l]); // R5
        end
    end

endmodule

// File: rtl/lsu_retire_pick.sv
module lsu_retire_pick #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 2
) (
    input  logic [DEPTH-1:0] done_vec,
    output logic             sel_valid,
    output logic [TAG_W-1:0] sel_idx
);

    always_comb begin
        sel_idx = '0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            if (done_vec[e]) sel_idx = TAG_W'(e);
        end
    end

    assign sel_valid = |done_vec;

endmodule

// File: rtl/lsu_tag_tracker.sv
module lsu_tag_tracker
    import lsu_pkg::*;
#(
    parameter  int LANES = 4,
    parameter  int DEPTH = 4,
    localparam int TAG_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES-1:0]        in_mask,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    input  logic                    in_store,
    input  logic                    in_fence,
    input  logic [ID_W-1:0]         in_id,
    output logic [LANES-1:0]        req_valid,
    output logic [LANES*ADDR_W-1:0] req_addr,
    output logic [LANES-1:0]        req_write,
    output logic [LANES*TAG_W-1:0]  req_tag,
    input  logic [LANES-1:0]        rsp_valid,
    input  logic [LANES*TAG_W-1:0]  rsp_tag,
    output logic                    out_valid,
    output logic [ID_W-1:0]         out_id,
    output logic                    out_store,
    output logic                    out_fence,
    output logic [LAT_W-1:0]        out_latency
);

    cyc_t             cyc_q;
    logic             hold_q;
    slot_meta_t       hold_meta_q;
    result_t          res_q;
    logic             res_valid_q;

    logic             accept;
    logic             alloc_en;
    logic [TAG_W-1:0] alloc_idx;
    slot_meta_t       new_meta;
    slot_meta_t       rel_meta;
    logic [DEPTH-1:0] done_vec;
    logic             tbl_full;
    logic             tbl_empty;
    logic             sel_valid;
    logic [TAG_W-1:0] sel_idx;
    logic             fence_fire;

    always_ff @(posedge clk) begin
        if (rst) cyc_q <= '0;
        else     cyc_q <= cyc_q + 1'b1;
    end

    // Stall on a held barrier, a full table, or a completion waiting to leave
    assign in_ready   = !hold_q && !tbl_full && !sel_valid;
    assign accept     = in_valid && in_ready;
    assign alloc_en   = accept && !in_fence;
    assign fence_fire = hold_q && tbl_empty;

    assign new_meta = '{id: in_id, store: in_store, issue: cyc_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
        end else if (accept && in_fence) begin
            hold_q <= 1'b1;
        end else if (fence_fire) begin
            hold_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (accept && in_fence) hold_meta_q <= new_meta;
    end

    lsu_lane_issue #(
        .LANES (LANES),
        .TAG_W (TAG_W)
    ) u_issue (
        .clk       (clk),
        .rst       (rst),
        .fire      (alloc_en),
        .mask      (in_mask),
        .addr      (in_addr),
        .write     (in_store),
        .tag       (alloc_idx),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_tag   (req_tag)
    );

    lsu_pend_table #(
        .LANES (LANES),
        .DEPTH (DEPTH),
        .TAG_W (TAG_W)
    ) u_table (
        .clk          (clk),
        .rst          (rst),
        .alloc_en     (alloc_en),
        .alloc_mask   (in_mask),
        .alloc_meta   (new_meta),
        .alloc_idx    (alloc_idx),
        .rsp_valid    (rsp_valid),
        .rsp_tag      (rsp_tag),
        .release_en   (sel_valid),
        .release_idx  (sel_idx),
        .release_meta (rel_meta),
        .done_vec     (done_vec),
        .full         (tbl_full),
        .empty        (tbl_empty)
    );

    lsu_retire_pick #(
        .DEPTH (DEPTH),
        .TAG_W (TAG_W)
    ) u_pick (
        .done_vec  (done_vec),
        .sel_valid (sel_valid),
        .sel_idx   (sel_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) res_valid_q <= 1'b0;
        else     res_valid_q <= sel_valid || fence_fire;
    end

    always_ff @(posedge clk) begin
        if (sel_valid) begin
            res_q <= '{id: rel_meta.id, store: rel_meta.store, fence: 1'b0,
                       latency: elapsed(cyc_q, rel_meta.issue)};
        end else if (fence_fire) begin
            res_q <= '{id: hold_meta_q.id, store: hold_meta_q.store, fence: 1'b1,
                       latency: elapsed(cyc_q, hold_meta_q.issue)};
        end
    end

    assign out_valid   = res_valid_q;
    assign out_id      = res_q.id;
    assign out_store   = res_q.store;
    assign out_fence   = res_q.fence;
    assign out_latency = res_q.latency;

    AST_REQ_WITHIN_MASK: assert property (@(posedge clk) disable iff (rst)
        (req_valid & ~$past(in_mask)) == '0); // R2

    AST_RESULT_FROM_DONE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_fence) |-> $past(done_vec != '0)); // R4

    AST_FENCE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fence) |-> $past(tbl_empty)); // R7

endmodule

// File: tb/lsu_tag_tracker_tb.sv
`timescale 1ns/1ps
module lsu_tag_tracker_tb;

    localparam int L  = 4;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [L-1:0]  in_mask = '0;
    logic [L*32-1:0] in_addr = '0;
    logic          in_store = 1'b0;
    logic          in_fence = 1'b0;
    logic [7:0]    in_id = '0;
    logic [L-1:0]  req_valid;
    logic [L*32-1:0] req_addr;
    logic [L-1:0]  req_write;
    logic [L*TW-1:0] req_tag;
    logic [L-1:0]  rsp_valid = '0;
    logic [L*TW-1:0] rsp_tag = '0;
    logic          out_valid;
    logic [7:0]    out_id;
    logic          out_store;
    logic          out_fence;
    logic [15:0]   out_latency;

    always #2 clk = ~clk;

    lsu_tag_tracker #(.LANES(L), .DEPTH(4)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_mask(in_mask), .in_addr(in_addr), .in_store(in_store),
        .in_fence(in_fence), .in_id(in_id), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .out_valid(out_valid),
        .out_id(out_id), .out_store(out_store), .out_fence(out_fence),
        .out_latency(out_latency)
    );

    typedef struct { int id; bit st; bit fen; } exp_t;
    exp_t exp_q[$];
    exp_t mon_e;
    int   acc_cyc [256];
    int   tb_cyc;
    int   checks = 0;
    int   fails  = 0;

    always @(posedge clk) begin
        if (rst) tb_cyc <= 0;
        else     tb_cyc <= tb_cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lane_addr(input int id, input int l);
        return 32'h1000 + 32'(id * 16) + 32'(l * 4);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_res(input int id, input bit st, input bit fen);
        exp_t e;
        e.id = id; e.st = st; e.fen = fen;
        exp_q.push_back(e);
    endtask

    // Driver: present at a negedge, hold until accepted; returns in the cycle after acceptance
    task automatic send(input int id, input logic [L-1:0] mask, input logic st, input logic fen);
        in_valid = 1'b1;
        in_id    = 8'(id);
        in_mask  = mask;
        in_store = st;
        in_fence = fen;
        for (int l = 0; l < L; l++) in_addr[l*32 +: 32] = lane_addr(id, l);
        while (!in_ready) @(negedge clk);
        acc_cyc[id] = tb_cyc;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic rsp(input logic [L-1:0] lanes, input logic [L*TW-1:0] tags);
        rsp_valid = lanes;
        rsp_tag   = tags;
        @(negedge clk);
        rsp_valid = '0;
        rsp_tag   = '0;
    endtask

    task automatic chk_req(input int id, input logic [L-1:0] mask, input logic st, input int tag);
        chk(req_valid == mask, "R2 request lanes", req_valid, mask);
        for (int l = 0; l < L; l++) begin
            if (mask[l]) begin
                chk(req_addr[l*32 +: 32] == lane_addr(id, l), "R2 lane address",
                    req_addr[l*32 +: 32], lane_addr(id, l));
                chk(req_write[l] == st, "R2 write bit", req_write[l], st);
                chk(req_tag[l*TW +: TW] == TW'(tag), "R3 shared tag",
                    req_tag[l*TW +: TW], tag);
            end
        end
    endtask

    // Monitor: compare every result with the scoreboard head
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected result", out_id, 0);
            end else begin
                mon_e = exp_q.pop_front();
                chk(out_id == 8'(mon_e.id) && out_store == mon_e.st && out_fence == mon_e.fen,
                    "R9 result order and content", {out_id, out_store, out_fence},
                    {8'(mon_e.id), mon_e.st, mon_e.fen});
                chk(out_latency == 16'(tb_cyc - 1 - acc_cyc[out_id]), "R8 latency",
                    out_latency, 16'(tb_cyc - 1 - acc_cyc[out_id]));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
        chk(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
        chk(req_valid == '0, "R1 req_valid", req_valid, 0);
        idle(1);

        // R2 R3 R4 R5: partial responses then the last lane
        send(1, 4'b1011, 1'b0, 1'b0);
        chk_req(1, 4'b1011, 1'b0, 0);
        rsp(4'b1001, 8'h00);
        chk(out_valid == 1'b0, "R5 no result while lanes pending", out_valid, 0);
        idle(1);
        chk(out_valid == 1'b0, "R5 no result while lanes pending", out_valid, 0);
        expect_res(1, 1'b0, 1'b0);
        rsp(4'b0010, 8'h00);
        idle(1);
        chk(out_valid == 1'b1 && out_id == 8'd1, "R4 result two cycles after last response",
            {out_valid, out_id}, {1'b1, 8'd1});
        idle(2);

        // R3 slot reuse, R5 out-of-order retirement
        send(2, 4'b1111, 1'b1, 1'b0);
        chk_req(2, 4'b1111, 1'b1, 0);
        send(3, 4'b0101, 1'b0, 1'b0);
        chk_req(3, 4'b0101, 1'b0, 1);
        expect_res(3, 1'b0, 1'b0);
        rsp(4'b0101, 8'b00_01_00_01);
        expect_res(2, 1'b1, 1'b0);
        rsp(4'b1111, 8'h00);
        idle(4);

        // R6 full table, R3 lowest free slot
        send(4, 4'b0001, 1'b0, 1'b0);
        chk_req(4, 4'b0001, 1'b0, 0);
        send(5, 4'b0010, 1'b0, 1'b0);
        chk_req(5, 4'b0010, 1'b0, 1);
        send(6, 4'b0100, 1'b1, 1'b0);
        chk_req(6, 4'b0100, 1'b1, 2);
        send(7, 4'b1000, 1'b0, 1'b0);
        chk_req(7, 4'b1000, 1'b0, 3);
        chk(in_ready == 1'b0, "R6 stall when full", in_ready, 0);
        idle(2);
        chk(in_ready == 1'b0, "R6 stall when full", in_ready, 0);
        expect_res(6, 1'b1, 1'b0);
        rsp(4'b0100, 8'b00_10_00_00);
        idle(1);
        chk(in_ready == 1'b1, "R6 accept after retire", in_ready, 1);
        send(8, 4'b0100, 1'b0, 1'b0);
        chk_req(8, 4'b0100, 1'b0, 2);

        // R9 simultaneous completions, lowest slot first
        expect_res(4, 1'b0, 1'b0);
        expect_res(5, 1'b0, 1'b0);
        expect_res(8, 1'b0, 1'b0);
        expect_res(7, 1'b0, 1'b0);
        rsp(4'b1111, 8'b11_10_01_00);
        chk(in_ready == 1'b0, "R9 stall while completions wait", in_ready, 0);
        idle(1);
        chk(in_ready == 1'b0, "R9 stall while completions wait", in_ready, 0);
        idle(5);
        chk(in_ready == 1'b1, "R9 input resumes", in_ready, 1);

        // R7 barrier waits for drain
        send(9, 4'b0011, 1'b0, 1'b0);
        chk_req(9, 4'b0011, 1'b0, 0);
        send(10, 4'b1111, 1'b0, 1'b1);
        chk(req_valid == '0, "R7 barrier issues nothing", req_valid, 0);
        chk(in_ready == 1'b0, "R7 barrier blocks input", in_ready, 0);
        idle(3);
        chk(in_ready == 1'b0 && out_valid == 1'b0, "R7 barrier held",
            {in_ready, out_valid}, 0);
        expect_res(9, 1'b0, 1'b0);
        expect_res(10, 1'b0, 1'b1);
        rsp(4'b0011, 8'h00);
        idle(1);
        chk(out_valid && !out_fence, "R7 load retires before barrier",
            {out_valid, out_fence}, 2'b10);
        idle(1);
        chk(out_valid && out_fence, "R7 barrier result after drain",
            {out_valid, out_fence}, 2'b11);
        chk(in_ready == 1'b1, "R7 input released", in_ready, 1);
        idle(1);

        // R7 barrier on an empty table
        expect_res(11, 1'b0, 1'b1);
        send(11, 4'b0000, 1'b0, 1'b1);
        idle(1);
        chk(out_valid && out_fence, "R7 barrier on empty table",
            {out_valid, out_fence}, 2'b11);
        idle(1);

        // R10 zero mask
        expect_res(12, 1'b1, 1'b0);
        send(12, 4'b0000, 1'b1, 1'b0);
        chk(req_valid == '0, "R10 no requests for empty mask", req_valid, 0);
        idle(1);
        chk(out_valid == 1'b1 && out_id == 8'd12, "R10 immediate result",
            {out_valid, out_id}, {1'b1, 8'd12});
        idle(3);

        chk(exp_q.size() == 0, "R4 all expected results seen", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule